// File: doc/BRIEF.md
# Configurable Registered Command Buffer

This block is a single clocked register stage placed on the address and command lines of a memory module. On every rising clock edge it loads an input word and presents it on its outputs. Two static strap inputs choose how it is used: either the whole input word is registered one to one at full width, or a narrower slice of the input is registered and presented twice, once on the main output bus and once on a second copy bus. Which slice is used in the copied mode is chosen by the second strap: the low slice or the high slice.

Two qualifier inputs control whether a capture takes effect. When both are high at a clock edge, the registers keep their old contents and the outputs do not move. When either is low, the new word is loaded. An active-low reset clears every register at once, without waiting for the clock, and overrides the qualifiers. Tying one qualifier low permanently turns the hold feature off, so the other qualifier can be used as an ordinary data bit.

Top module: `cmdbuf_top`

## Requirements
- R1: While `rst_n` is low, `q_main` and `q_copy` are all zero, and they go to zero without waiting for a clock edge.
- R2: With `cfg_dual` = 0 (wide mode) and a load edge, `q_main` takes the full 25-bit `din` sampled at that rising edge, and `q_copy` is zero.
- R3: With `cfg_dual` = 1 and `cfg_upper` = 0 (low slice), a load edge puts `din[13:0]` on both `q_main[13:0]` and `q_copy[13:0]`, and `q_main[24:14]` is zero.
- R4: With `cfg_dual` = 1 and `cfg_upper` = 1 (high slice), a load edge puts `din[24:11]` on both `q_main[24:11]` and `q_copy[13:0]`, and `q_main[10:0]` is zero.
- R5: A rising edge at which `sel_pri` and `sel_aux` are both 1 leaves `q_main` and `q_copy` unchanged, whatever `din` holds.
- R6: A rising edge at which at least one of `sel_pri`, `sel_aux` is 0 is a load edge; with `sel_aux` tied to 0, toggling `sel_pri` never stops a load.
- R7: Driving `rst_n` low clears the outputs even while both qualifiers are 1.
- R8: In wide mode the value of `cfg_upper` has no effect on the outputs.
- R9: In either copied mode, the input bits outside the selected slice have no effect on any output.
- R10: After `rst_n` is released with `din` held at zero and a running clock, the outputs stay zero on every edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_dual | input | 1 | Strap: 0 = wide one-to-one, 1 = narrow slice copied to two buses |
| cfg_upper | input | 1 | Strap: slice choice in copied mode, 0 = low bits, 1 = high bits |
| sel_pri | input | 1 | First hold qualifier |
| sel_aux | input | 1 | Second hold qualifier |
| din | input | 25 | Input word |
| q_main | output | 25 | Registered main output bus |
| q_copy | output | 14 | Registered second copy of the narrow slice |

## Verification
The bench drives each mode with walking, alternating and pseudo-random words, so a swapped slice offset, a missing copy or a bit leaking across the slice border shows up as a wrong bit position. Words with ones only in the unused input bits separate a correct slice mask from one that passes everything, and changing `cfg_upper` in wide mode exposes a decode that looks at it too early. Hold edges carry fresh data, so a gate that ignores one qualifier loads visibly; toggling one qualifier with the other tied low tells an AND hold from an OR hold. Resets dropped in the middle of a cycle, with the qualifiers high, show whether clearing is truly asynchronous and wins over the hold.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;

    typedef enum logic [1:0] {
        MODE_WIDE   = 2'd0,
        MODE_DUAL_A = 2'd1,
        MODE_DUAL_B = 2'd2
    } cmdbuf_mode_e;

    function automatic cmdbuf_mode_e decode_mode(input logic dual, input logic upper);
        cmdbuf_mode_e m;
        if (!dual) begin
            m = MODE_WIDE;
        end else if (!upper) begin
            m = MODE_DUAL_A;
        end else begin
            m = MODE_DUAL_B;
        end
        return m;
    endfunction

endpackage

// File: rtl/cmdbuf_select.sv
module cmdbuf_select
    import cmdbuf_pkg::*;
#(
    parameter int FULL_W = 25,
    parameter int HALF_W = 14
) (
    input  cmdbuf_mode_e        mode,
    input  logic [FULL_W-1:0]   din,
    output logic [FULL_W-1:0]   main_nxt,
    output logic [HALF_W-1:0]   copy_nxt
);
    localparam int OFS = FULL_W - HALF_W;

    // Main bus: each bit is passed or masked depending on the slice it falls in.
    for (genvar i = 0; i < FULL_W; i++) begin : g_main
        localparam bit IN_LOW  = (i < HALF_W);
        localparam bit IN_HIGH = (i >= OFS);
        always_comb begin
            case (mode)
                MODE_WIDE:   main_nxt[i] = din[i];
                MODE_DUAL_A: main_nxt[i] = IN_LOW  ? din[i] : 1'b0;
                MODE_DUAL_B: main_nxt[i] = IN_HIGH ? din[i] : 1'b0;
                default:     main_nxt[i] = 1'b0;
            endcase
        end
    end

    // Copy bus: the selected slice, right aligned.
    for (genvar j = 0; j < HALF_W; j++) begin : g_copy
        always_comb begin
            case (mode)
                MODE_DUAL_A: copy_nxt[j] = din[j];
                MODE_DUAL_B: copy_nxt[j] = din[j+OFS];
                default:     copy_nxt[j] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/cmdbuf_gate.sv
module cmdbuf_gate (
    input  logic sel_pri,
    input  logic sel_aux,
    output logic load_en
);
    // Hold only when both qualifiers are high.
    always_comb begin
        load_en = !(sel_pri && sel_aux);
    end

endmodule

// File: rtl/cmdbuf_top.sv
module cmdbuf_top
    import cmdbuf_pkg::*;
#(
    parameter int FULL_W = 25,
    parameter int HALF_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_dual,
    input  logic              cfg_upper,
    input  logic              sel_pri,
    input  logic              sel_aux,
    input  logic [FULL_W-1:0] din,
    output logic [FULL_W-1:0] q_main,
    output logic [HALF_W-1:0] q_copy
);
    typedef struct packed {
        logic [FULL_W-1:0] main;
        logic [HALF_W-1:0] copy;
    } buf_state_t;

    cmdbuf_mode_e      mode;
    logic [FULL_W-1:0] main_nxt;
    logic [HALF_W-1:0] copy_nxt;
    logic              load_en;
    buf_state_t        st_d;
    buf_state_t        st_q;

    always_comb begin
        mode = decode_mode(cfg_dual, cfg_upper);
    end

    cmdbuf_select #(
        .FULL_W (FULL_W),
        .HALF_W (HALF_W)
    ) i_select (
        .mode     (mode),
        .din      (din),
        .main_nxt (main_nxt),
        .copy_nxt (copy_nxt)
    );

    cmdbuf_gate i_gate (
        .sel_pri (sel_pri),
        .sel_aux (sel_aux),
        .load_en (load_en)
    );

    always_comb begin
        st_d = st_q;
        if (load_en) begin
            st_d.main = main_nxt;
            st_d.copy = copy_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_main = st_q.main;
    assign q_copy = st_q.copy;

endmodule

// File: rtl/cmdbuf_checker.sv
module cmdbuf_checker #(
    parameter int FULL_W = 25,
    parameter int HALF_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_dual,
    input logic              cfg_upper,
    input logic              sel_pri,
    input logic              sel_aux,
    input logic [FULL_W-1:0] din,
    input logic [FULL_W-1:0] q_main,
    input logic [HALF_W-1:0] q_copy
);
    localparam int OFS = FULL_W - HALF_W;

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |-> (q_main == '0 && q_copy == '0));

    p_wide_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_dual && !(sel_pri && sel_aux)) |=>
            (q_main == $past(din) && q_copy == '0));

    p_dual_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dual && !cfg_upper && !(sel_pri && sel_aux)) |=>
            (q_copy == $past(din[HALF_W-1:0]) &&
             q_main[HALF_W-1:0] == q_copy &&
             q_main[FULL_W-1:HALF_W] == '0));

    p_dual_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dual && cfg_upper && !(sel_pri && sel_aux)) |=>
            (q_copy == $past(din[FULL_W-1:OFS]) &&
             q_main[FULL_W-1:OFS] == q_copy &&
             q_main[OFS-1:0] == '0));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_pri && sel_aux) |=> ($stable(q_main) && $stable(q_copy)));

    p_one_low_loads_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_aux && cfg_dual == 1'b0) |=> (q_main == $past(din)));

endmodule

bind cmdbuf_top cmdbuf_checker #(
    .FULL_W (FULL_W),
    .HALF_W (HALF_W)
) i_cmdbuf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_dual  (cfg_dual),
    .cfg_upper (cfg_upper),
    .sel_pri   (sel_pri),
    .sel_aux   (sel_aux),
    .din       (din),
    .q_main    (q_main),
    .q_copy    (q_copy)
);

// File: tb/test_cmdbuf_top.sv
module test_cmdbuf_top;
    localparam int CLK_PERIOD = 10;
    localparam int W   = 25;
    localparam int H   = 14;
    localparam int OFS = W - H;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_dual = 1'b0;
    logic         cfg_upper = 1'b0;
    logic         sel_pri = 1'b0;
    logic         sel_aux = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] q_main;
    logic [H-1:0] q_copy;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [W-1:0] ref_m = '0;
    logic [H-1:0] ref_c = '0;
    logic [W-1:0] exp_m[$];
    logic [H-1:0] exp_c[$];
    string        exp_tag[$];
    logic [W-1:0] lfsr = 25'h1ACE5;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmdbuf_top i_cmdbuf_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_dual  (cfg_dual),
        .cfg_upper (cfg_upper),
        .sel_pri   (sel_pri),
        .sel_aux   (sel_aux),
        .din       (din),
        .q_main    (q_main),
        .q_copy    (q_copy)
    );

    task automatic check(string tag, logic [W-1:0] am, logic [H-1:0] ac,
                         logic [W-1:0] em, logic [H-1:0] ec);
        total++;
        if (am !== em || ac !== ec) begin
            bad++;
            $display("FAIL %s: actual main=%h copy=%h expected main=%h copy=%h",
                     tag, am, ac, em, ec);
        end
    endtask

    // Expected outputs after a load edge, from the requirements.
    task automatic model(input logic [W-1:0] d, input logic dual, input logic upper,
                         output logic [W-1:0] m, output logic [H-1:0] c);
        if (!dual) begin
            m = d;
            c = '0;
        end else if (!upper) begin
            m = {{(W-H){1'b0}}, d[H-1:0]};
            c = d[H-1:0];
        end else begin
            m = {d[W-1:OFS], {OFS{1'b0}}};
            c = d[W-1:OFS];
        end
    endtask

    function automatic logic [W-1:0] next_rand(logic [W-1:0] v);
        return {v[W-2:0], v[24] ^ v[21]};
    endfunction

    // Driver: applies one cycle of stimulus and pushes the expected result.
    task automatic step(string tag, logic [W-1:0] d, logic dual, logic upper,
                        logic sp, logic sa);
        logic [W-1:0] m;
        logic [H-1:0] c;
        @(negedge clk);
        din       = d;
        cfg_dual  = dual;
        cfg_upper = upper;
        sel_pri   = sp;
        sel_aux   = sa;
        if (!(sp && sa)) begin
            model(d, dual, upper, m, c);
            ref_m = m;
            ref_c = c;
        end
        exp_m.push_back(ref_m);
        exp_c.push_back(ref_c);
        exp_tag.push_back(tag);
    endtask

    // Monitor: compares each result a quarter period after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_m.size() > 0) begin
                check(exp_tag.pop_front(), q_main, q_copy,
                      exp_m.pop_front(), exp_c.pop_front());
            end
        end
    end

    task automatic drain();
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset held with busy inputs
        din = 25'h1FFFFFF;
        sel_pri = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset state", q_main, q_copy, '0, '0);

        // R10: release reset with zero inputs, outputs stay low
        din = '0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) step("R10 quiet after reset", '0, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 2; k++) step("R10 quiet after reset dual", '0, 1'b1, 1'b1, 1'b0, 1'b0);

        // R2: wide mode patterns
        step("R2 wide all ones", 25'h1FFFFFF, 1'b0, 1'b0, 1'b0, 1'b0);
        step("R2 wide alternating", 25'h0AAAAAA, 1'b0, 1'b0, 1'b1, 1'b0);
        step("R2 wide alternating inv", 25'h1555555, 1'b0, 1'b0, 1'b0, 1'b1);
        for (int k = 0; k < W; k++) step("R2 wide walking one", 25'd1 << k, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 8; k++) begin
            lfsr = next_rand(lfsr);
            step("R2 wide random", lfsr, 1'b0, 1'b0, 1'b0, 1'b0);
        end

        // R8: cfg_upper ignored in wide mode
        step("R8 wide with upper set", 25'h0F0F0F3, 1'b0, 1'b1, 1'b0, 1'b0);
        step("R8 wide with upper set b", 25'h1C33A55, 1'b0, 1'b1, 1'b0, 1'b0);

        // R5: hold with fresh data
        step("R5 hold wide", 25'h0000001, 1'b0, 1'b0, 1'b1, 1'b1);
        step("R5 hold wide b", 25'h1FFFFFF, 1'b0, 1'b0, 1'b1, 1'b1);
        step("R5 resume", 25'h0123456, 1'b0, 1'b0, 1'b1, 1'b0);

        // R6: sel_aux tied low, sel_pri used as data
        for (int k = 0; k < 6; k++) begin
            lfsr = next_rand(lfsr);
            step("R6 one qualifier low", lfsr, 1'b0, 1'b0, k[0], 1'b0);
        end
        step("R6 other qualifier low", 25'h1234567, 1'b0, 1'b0, 1'b0, 1'b1);

        // R3: low slice, copied
        step("R3 low slice ones", 25'h0003FFF, 1'b1, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < H; k++) step("R3 low slice walking", 25'd1 << k, 1'b1, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 6; k++) begin
            lfsr = next_rand(lfsr);
            step("R3 low slice random", lfsr, 1'b1, 1'b0, 1'b0, 1'b0);
        end
        // R9: only unused bits set in low slice mode
        step("R9 low slice unused bits", 25'h1FFC000, 1'b1, 1'b0, 1'b0, 1'b0);
        step("R5 hold dual low", 25'h0001234, 1'b1, 1'b0, 1'b1, 1'b1);

        // R4: high slice, copied
        step("R4 high slice ones", 25'h1FFF800, 1'b1, 1'b1, 1'b0, 1'b0);
        for (int k = OFS; k < W; k++) step("R4 high slice walking", 25'd1 << k, 1'b1, 1'b1, 1'b0, 1'b0);
        for (int k = 0; k < 6; k++) begin
            lfsr = next_rand(lfsr);
            step("R4 high slice random", lfsr, 1'b1, 1'b1, 1'b0, 1'b0);
        end
        // R9: only unused bits set in high slice mode
        step("R9 high slice unused bits", 25'h00007FF, 1'b1, 1'b1, 1'b0, 1'b0);
        step("R4 load before hold", 25'h1A5A000, 1'b1, 1'b1, 1'b0, 1'b0);
        step("R5 hold dual high", 25'h0000000, 1'b1, 1'b1, 1'b1, 1'b1);
        drain();

        // R7: asynchronous reset mid-cycle while holding
        sel_pri = 1'b1;
        sel_aux = 1'b1;
        #(CLK_PERIOD/4);
        rst_n = 1'b0;
        #1;
        check("R7 reset wins over hold", q_main, q_copy, '0, '0);
        check("R1 async clear before edge", q_main, q_copy, '0, '0);
        ref_m = '0;
        ref_c = '0;
        @(negedge clk);
        din = '0;
        rst_n = 1'b1;
        step("R10 quiet after second reset", '0, 1'b1, 1'b1, 1'b0, 1'b0);
        step("R2 wide after reset", 25'h1DEAD55, 1'b0, 1'b0, 1'b0, 1'b0);
        drain();

        finish_run();
    end

endmodule